// File: doc/BRIEF.md
# Software-Loaded Translation Lookaside Buffer

This block is a small fully associative translation cache. It maps virtual page numbers to physical frame numbers. A lookup presents a virtual address. Every valid entry compares its page tag against that address in parallel, and on a match the physical address is formed in the same cycle from the cached frame and the untranslated offset bits.

When nothing matches, the block does not search any tables in memory. It raises a miss flag, which the surrounding core turns into a trap. The trap handler computes the translation, writes it into an entry index of its own choice through the load port, and retries the access.

Each entry holds four things:
- a valid bit;
- a size flag, which selects a 4 KB page or a 2 MB superpage;
- a write-permission bit;
- the tag and frame fields.

A superpage entry matches on fewer tag bits and passes more of the address through untranslated. A store lookup that lands on an entry without write permission raises a protection fault, which is kept separate from a miss. Software can invalidate one entry at a time or flush the whole buffer in a single cycle.

Top module: `soft_tlb`

## Requirements
- R1: For a lookup (`lk_valid`=1), a valid 4 KB entry (size flag 0) whose 20-bit tag equals `lk_va[31:12]` produces, combinationally in the same cycle, `lk_hit`=1, `lk_miss`=0, `lk_idx` = the entry index, and `lk_pa` = {frame[19:0], `lk_va[11:0]`}.
- R2: A valid superpage entry (size flag 1) compares only tag bits [19:9] with `lk_va[31:21]`, and on a hit gives `lk_pa` = {frame[19:9], `lk_va[20:0]`}. The frame's low 9 bits are ignored.
- R3: For a lookup that matches no valid entry, `lk_miss`=1, `lk_hit`=0, `lk_fault`=0, `lk_idx`=0 and `lk_pa`=0.
- R4: With `lk_valid`=0, the outputs `lk_hit`, `lk_miss` and `lk_fault` are 0, and `lk_pa` and `lk_idx` are 0, whatever the stored contents are.
- R5: When several valid entries match, the lowest-indexed one supplies `lk_idx` and `lk_pa`.
- R6: A lookup with `lk_store`=1 that hits an entry whose write-permission bit is 0 gives `lk_fault`=1, with `lk_hit` still 1 and `lk_pa` still formed. A load lookup (`lk_store`=0), or a store lookup to an entry that permits writes, gives `lk_fault`=0.
- R7: With `ld_en`=1, entry `ld_idx` is written with the tag, frame, size flag and write permission, and is made valid at the clock edge. Lookups in that same cycle still see the old contents. A rewrite replaces the previous mapping.
- R8: With `inv_en`=1, the valid bit of entry `inv_idx` clears at the clock edge and no other entry changes. When a load names the same index in the same cycle, the invalidate wins.
- R9: With `flush_all`=1, every valid bit clears at one clock edge. The flush overrides any load or invalidate in the same cycle.
- R10: Synchronous active-high `rst` clears every valid bit, so that all lookups after reset miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_va | input | 32 | Virtual address to translate |
| lk_store | input | 1 | Lookup is for a store access |
| lk_hit | output | 1 | A valid entry matched |
| lk_miss | output | 1 | Lookup found no entry (trap request) |
| lk_fault | output | 1 | Store hit an entry without write permission |
| lk_pa | output | 32 | Translated physical address, 0 unless hit |
| lk_idx | output | 4 | Index of the selected entry, 0 unless hit |
| ld_en | input | 1 | Write an entry |
| ld_idx | input | 4 | Entry index to write |
| ld_vpn | input | 20 | Virtual page tag to store |
| ld_pfn | input | 20 | Physical frame to store |
| ld_super | input | 1 | Entry maps a 2 MB superpage |
| ld_writable | input | 1 | Entry permits stores |
| inv_en | input | 1 | Invalidate one entry |
| inv_idx | input | 4 | Entry index to invalidate |
| flush_all | input | 1 | Invalidate every entry |

## Verification
Any stale or wrong stored state reaches the ports within one cycle of the next lookup that touches it, because the lookup path is purely combinational from the entry state to the outputs. Three examples:
- A valid bit that survives an invalidate or a flush shows up as a hit where a miss is expected.
- A corrupted frame or size flag shows up as a wrong physical address.
- A broken priority chain shows up as the wrong index when entries overlap.

For these reasons the bench compares every output on every cycle against a behavioural model. It deliberately places overlapping entries and superpages around tag boundaries.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  // Outcome of one lookup, decoded into port flags by the top.
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_HIT   = 2'd1,
    OUT_MISS  = 2'd2,
    OUT_FAULT = 2'd3
  } lk_outcome_e;

  function automatic lk_outcome_e classify(input logic req,
                                           input logic any_match,
                                           input logic store,
                                           input logic writable);
    if (!req)                       return OUT_NONE;
    else if (!any_match)            return OUT_MISS;
    else if (store && !writable)    return OUT_FAULT;
    else                            return OUT_HIT;
  endfunction

endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic             ld_super,
  input  logic             ld_writable,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             flush_all,
  output logic [ENTRIES-1:0] valid_o,
  output logic [VPN_W-1:0] vpn_o   [ENTRIES],
  output logic [PFN_W-1:0] pfn_o   [ENTRIES],
  output logic [ENTRIES-1:0] super_o,
  output logic [ENTRIES-1:0] wr_o
);

  logic [ENTRIES-1:0] valid_q;
  logic [VPN_W-1:0]   vpn_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];
  logic [ENTRIES-1:0] super_q;
  logic [ENTRIES-1:0] wr_q;
  logic               ld_blocked;

  // An invalidate of the same slot in the same cycle wins over a load.
  assign ld_blocked = inv_en && (inv_idx == ld_idx);

  // Valid bits live in flops so that a flush clears them all in one edge.
  always_ff @(posedge clk) begin
    if (rst || flush_all) begin
      valid_q <= '0;
    end else begin
      if (ld_en && !ld_blocked) valid_q[ld_idx] <= 1'b1;
      if (inv_en)               valid_q[inv_idx] <= 1'b0;
    end
  end

  // Payload fields: single write port, no reset.
  always_ff @(posedge clk) begin
    if (ld_en) begin
      vpn_q[ld_idx]   <= ld_vpn;
      pfn_q[ld_idx]   <= ld_pfn;
      super_q[ld_idx] <= ld_super;
      wr_q[ld_idx]    <= ld_writable;
    end
  end

  assign valid_o = valid_q;
  assign vpn_o   = vpn_q;
  assign pfn_o   = pfn_q;
  assign super_o = super_q;
  assign wr_o    = wr_q;

  // R10: reset leaves no entry valid.
  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (valid_q == '0));

  // R9: a flush leaves no entry valid.
  a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> (valid_q == '0));

  // R8: the invalidated slot is clear after the edge.
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (rst)
    inv_en |=> !valid_q[$past(inv_idx)]);

  // R7: an unblocked load makes its slot valid.
  a_r7_load_sets: assert property (@(posedge clk) disable iff (rst)
    (ld_en && !flush_all && !(inv_en && inv_idx == ld_idx))
      |=> valid_q[$past(ld_idx)]);

endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES    = 16,
  parameter int VPN_W      = 20,
  parameter int SUPER_BITS = 9
) (
  input  logic [VPN_W-1:0]   va_vpn,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [VPN_W-1:0]   vpn_i [ENTRIES],
  input  logic [ENTRIES-1:0] super_i,
  output logic [ENTRIES-1:0] match_o
);

  localparam int HI_W = VPN_W - SUPER_BITS;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    logic hi_eq;
    logic lo_eq;
    assign hi_eq = (vpn_i[g][VPN_W-1:SUPER_BITS] == va_vpn[VPN_W-1:SUPER_BITS]);
    assign lo_eq = (vpn_i[g][SUPER_BITS-1:0] == va_vpn[SUPER_BITS-1:0]);
    // Superpages skip the low tag bits.
    assign match_o[g] = valid_i[g] && hi_eq && (super_i[g] || lo_eq);
  end

  // R1: a match can only come from a valid entry.
  always_comb begin
    a_r1_match_needs_valid: assert ((match_o & ~valid_i) == '0);
  end

  if (HI_W < 1) begin : g_bad_cfg
    initial $error("tlb_match: SUPER_BITS must be below VPN_W");
  end

endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     sel_o
);

  // Scan downwards so the lowest set request is written last.
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |req;
  assign sel_o = any_o ? (N'(1) << idx_o) : '0;

  // R5: exactly one winner, taken from the requests, and none below it.
  always_comb begin
    a_r5_sel_onehot: assert ($onehot0(sel_o));
    a_r5_sel_in_req: assert ((sel_o & ~req) == '0);
    a_r5_lowest: assert (((sel_o - N'(1)) & req) == '0);
  end

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int OFF_W      = 12,
  parameter int SUPER_BITS = 9,
  parameter int IDX_W      = $clog2(ENTRIES),
  parameter int VPN_W      = VA_W - OFF_W,
  parameter int PFN_W      = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lk_valid,
  input  logic [VA_W-1:0]  lk_va,
  input  logic             lk_store,
  output logic             lk_hit,
  output logic             lk_miss,
  output logic             lk_fault,
  output logic [PA_W-1:0]  lk_pa,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [VPN_W-1:0] ld_vpn,
  input  logic [PFN_W-1:0] ld_pfn,
  input  logic             ld_super,
  input  logic             ld_writable,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic             flush_all
);
  import tlb_pkg::*;

  localparam int SP_OFF_W = OFF_W + SUPER_BITS;

  logic [ENTRIES-1:0] valid_w;
  logic [VPN_W-1:0]   vpn_w [ENTRIES];
  logic [PFN_W-1:0]   pfn_w [ENTRIES];
  logic [ENTRIES-1:0] super_w;
  logic [ENTRIES-1:0] wr_w;
  logic [ENTRIES-1:0] match_w;
  logic [ENTRIES-1:0] sel_w;
  logic               any_w;
  logic [IDX_W-1:0]   win_idx;
  logic [PFN_W-1:0]   win_pfn;
  logic [PA_W-1:0]    pa_page;
  logic [PA_W-1:0]    pa_super;
  lk_outcome_e        outcome;

  tlb_entry_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .VPN_W(VPN_W), .PFN_W(PFN_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_vpn(ld_vpn), .ld_pfn(ld_pfn),
    .ld_super(ld_super), .ld_writable(ld_writable),
    .inv_en(inv_en), .inv_idx(inv_idx), .flush_all(flush_all),
    .valid_o(valid_w), .vpn_o(vpn_w), .pfn_o(pfn_w),
    .super_o(super_w), .wr_o(wr_w)
  );

  tlb_match #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .SUPER_BITS(SUPER_BITS)
  ) u_match (
    .va_vpn(lk_va[VA_W-1:OFF_W]), .valid_i(valid_w), .vpn_i(vpn_w),
    .super_i(super_w), .match_o(match_w)
  );

  tlb_prio_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req(match_w), .any_o(any_w), .idx_o(win_idx), .sel_o(sel_w)
  );

  assign win_pfn  = pfn_w[win_idx];
  assign pa_page  = {win_pfn, lk_va[OFF_W-1:0]};
  assign pa_super = {win_pfn[PFN_W-1:SUPER_BITS], lk_va[SP_OFF_W-1:0]};
  assign outcome  = classify(lk_valid, any_w, lk_store, wr_w[win_idx]);

  always_comb begin
    lk_hit   = (outcome == OUT_HIT) || (outcome == OUT_FAULT);
    lk_miss  = (outcome == OUT_MISS);
    lk_fault = (outcome == OUT_FAULT);
    lk_idx   = lk_hit ? win_idx : '0;
    lk_pa    = '0;
    if (lk_hit) lk_pa = super_w[win_idx] ? pa_super : pa_page;
  end

  // R3: a miss and a hit never coincide, and a miss only follows a request.
  a_r3_miss_excl: assert property (@(posedge clk) disable iff (rst)
    lk_miss |-> (!lk_hit && !lk_fault && lk_valid && lk_pa == '0));

  // R4: nothing is flagged without a request.
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |-> (!lk_hit && !lk_miss && !lk_fault));

  // R6: a fault only on a store that hit.
  a_r6_fault_store: assert property (@(posedge clk) disable iff (rst)
    lk_fault |-> (lk_hit && lk_store));

  // R9: after a flush, the next lookup cannot hit.
  a_r9_no_hit_after_flush: assert property (@(posedge clk) disable iff (rst)
    flush_all |=> !lk_hit);

  // R5: the reported index comes from a matching entry.
  a_r5_idx_matches: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> sel_w[lk_idx]);

endmodule

// File: tb/soft_tlb_bench.sv
`timescale 1ns/1ps
module soft_tlb_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_store = 1'b0;
  logic        lk_hit, lk_miss, lk_fault;
  logic [31:0] lk_pa;
  logic [3:0]  lk_idx;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [19:0] ld_vpn = '0;
  logic [19:0] ld_pfn = '0;
  logic        ld_super = 1'b0;
  logic        ld_writable = 1'b0;
  logic        inv_en = 1'b0;
  logic [3:0]  inv_idx = '0;
  logic        flush_all = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state.
  bit          m_valid [16];
  logic [19:0] m_vpn   [16];
  logic [19:0] m_pfn   [16];
  bit          m_sup   [16];
  bit          m_wr    [16];

  always #2.5 clk = ~clk;

  soft_tlb u_soft_tlb (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_va(lk_va),
    .lk_store(lk_store), .lk_hit(lk_hit), .lk_miss(lk_miss),
    .lk_fault(lk_fault), .lk_pa(lk_pa), .lk_idx(lk_idx),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_vpn(ld_vpn), .ld_pfn(ld_pfn),
    .ld_super(ld_super), .ld_writable(ld_writable),
    .inv_en(inv_en), .inv_idx(inv_idx), .flush_all(flush_all)
  );

  // Compare outputs against the model, then advance the model past the edge.
  task automatic check_and_update(input string tag);
    bit e_hit = 0, e_miss = 0, e_fault = 0;
    logic [31:0] e_pa = '0;
    logic [3:0]  e_idx = '0;
    int nmatch = 0;
    string t;
    logic [40:0] act, exp;
    if (lk_valid) begin
      for (int i = 0; i < 16; i++) begin
        bit m;
        m = m_valid[i] && (m_sup[i] ? (m_vpn[i][19:9] == lk_va[31:21])
                                    : (m_vpn[i] == lk_va[31:12]));
        if (m) begin
          nmatch++;
          if (!e_hit) begin
            e_hit = 1;
            e_idx = 4'(i);
            e_pa = m_sup[i] ? {m_pfn[i][19:9], lk_va[20:0]}
                            : {m_pfn[i], lk_va[11:0]};
            e_fault = lk_store && !m_wr[i];
          end
        end
      end
      e_miss = !e_hit;
    end
    t = tag;
    if (t == "") begin
      if (!lk_valid) t = "R4";
      else if (e_miss) t = "R3";
      else if (e_fault) t = "R6";
      else if (nmatch > 1) t = "R5";
      else if (m_sup[e_idx]) t = "R2";
      else t = "R1";
    end
    act = {lk_hit, lk_miss, lk_fault, lk_idx, 2'b00, lk_pa};
    exp = {e_hit, e_miss, e_fault, e_idx, 2'b00, e_pa};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s t=%0t hit/miss/fault/idx/pa actual=%h expected=%h",
               t, $time, act, exp);
    end
    // Model of the state update at the coming edge.
    if (rst || flush_all) begin
      for (int i = 0; i < 16; i++) m_valid[i] = 0;
    end else begin
      if (ld_en) begin
        m_vpn[ld_idx] = ld_vpn; m_pfn[ld_idx] = ld_pfn;
        m_sup[ld_idx] = ld_super; m_wr[ld_idx] = ld_writable;
        if (!(inv_en && inv_idx == ld_idx)) m_valid[ld_idx] = 1;
      end
      if (inv_en) m_valid[inv_idx] = 0;
    end
  endtask

  task automatic idle_ctrl();
    ld_en = 0; inv_en = 0; flush_all = 0;
  endtask

  task automatic cycle(input string tag);
    #1;
    check_and_update(tag);
    @(negedge clk);
    idle_ctrl();
  endtask

  task automatic look(input logic [31:0] va, input bit st, input string tag);
    lk_valid = 1; lk_va = va; lk_store = st;
    cycle(tag);
  endtask

  task automatic load(input int idx, input logic [19:0] vpn,
                      input logic [19:0] pfn, input bit sup, input bit wr);
    ld_en = 1; ld_idx = 4'(idx); ld_vpn = vpn; ld_pfn = pfn;
    ld_super = sup; ld_writable = wr;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 0; m_vpn[i] = '0; m_pfn[i] = '0; m_sup[i] = 0; m_wr[i] = 0;
    end
    @(negedge clk);
    // R10: reset; lookups afterwards miss
    cycle("R10"); cycle("R10");
    rst = 0;
    look(32'h1234_5678, 0, "R10");
    lk_valid = 0; cycle("R4");

    // R7: a load is not visible in its own cycle, visible in the next
    load(3, 20'h12345, 20'hABCDE, 0, 1);
    look(32'h1234_5ABC, 0, "R7");
    look(32'h1234_5ABC, 0, "R1");
    look(32'h1234_5000, 1, "R1");
    look(32'h1234_4FFF, 0, "R3");
    lk_valid = 0; cycle("R4");

    // R2: superpage covering tags 0x40000..0x401FF
    load(7, 20'h40000, 20'h55555, 1, 1);
    lk_valid = 0; cycle("R7");
    look(32'h401F_F123, 0, "R2");
    look(32'h4000_0000, 0, "R2");
    look(32'h4020_0000, 0, "R3");

    // R5: two entries with the same tag; the lower index wins
    load(9, 20'h0BEEF, 20'h11111, 0, 1);
    lk_valid = 0; cycle("R7");
    load(1, 20'h0BEEF, 20'h22222, 0, 1);
    lk_valid = 0; cycle("R7");
    look(32'h0BEE_F010, 0, "R5");
    inv_en = 1; inv_idx = 4'd1;
    look(32'h0BEE_F010, 0, "R5");
    look(32'h0BEE_F010, 0, "R8");

    // R6: read-only entry
    load(5, 20'h00777, 20'h00999, 0, 0);
    lk_valid = 0; cycle("R7");
    look(32'h0077_7444, 0, "R6");
    look(32'h0077_7444, 1, "R6");
    look(32'h1234_5444, 1, "R6");

    // R7: overwrite replaces the previous mapping
    load(3, 20'h12345, 20'h0F0F0, 0, 1);
    lk_valid = 0; cycle("R7");
    look(32'h1234_5ABC, 0, "R7");

    // R8: invalidate beats a load to the same slot
    load(12, 20'h33333, 20'h44444, 0, 1);
    inv_en = 1; inv_idx = 4'd12;
    look(32'h3333_3000, 0, "R8");
    look(32'h3333_3000, 0, "R8");
    look(32'h0077_7000, 0, "R8");

    // R9: flush beats a load in the same cycle
    load(2, 20'h66666, 20'h77777, 0, 1);
    flush_all = 1;
    look(32'h401F_F123, 0, "R9");
    look(32'h401F_F123, 0, "R9");
    look(32'h6666_6000, 0, "R9");
    look(32'h0BEE_F000, 0, "R9");

    // Mixed traffic drawn from a small tag set so that hits and overlaps occur.
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 99);
      logic [19:0] tg = {8'h5A, 3'($urandom_range(0, 3)), 9'($urandom_range(0, 3))};
      if (r < 30) load($urandom_range(0, 15), tg, 20'($urandom),
                       bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      if (r >= 30 && r < 38) begin inv_en = 1; inv_idx = 4'($urandom_range(0, 15)); end
      if (r == 99) flush_all = 1;
      lk_valid = bit'($urandom_range(0, 7) != 0);
      lk_va = {tg, 12'($urandom)};
      lk_store = bit'($urandom_range(0, 1));
      cycle("");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule